// File: doc/BRIEF.md
# Comparator-Triggered Timer Capture Controller

This block is the digital half of a single-slope (ramp) voltage measurement. A free-running 16-bit counter advances on every enabled clock tick. A capture register takes a copy of that count when the selected capture source shows its active edge. The source is either an external capture pin or the output flag of the second analog comparator. Software, or a timer event, starts the ramp. The comparator flips when the ramp voltage passes the unknown voltage, and the captured count records the moment of crossing.

A small control register holds four settings: the capture-source select, the active edge, the capture interrupt enable and the analog interrupt enable. When a ramp-conversion mode is entered, the source select switches itself over to the comparator. A status register holds two sticky flags, one for capture and one for analog, and each is cleared by writing a one to it. The block drives two interrupt requests and a priority-resolved source code. Capture has precedence over analog, and an analog request stays pending until it is cleared, whatever the comparators do afterwards.

Top module: `ctc_capture_ctrl`

## Requirements
- R1: The counter rises by one at every clock edge where `tick_en` is 1 and wraps at 16 bits. It holds while `tick_en` is 0. Its live value reads at address 4 (high byte) and address 5 (low byte).
- R2: After reset the control byte (address 0), the status byte (address 1) and the counter read 0, and `irq_capture`, `irq_analog` and `irq_src` are 0.
- R3: Control bit 0 picks the capture source: 1 selects `cmp2_flag` and 0 selects `cap_pin`. Edges on the unselected input cause no capture.
- R4: Control bit 3 picks the active edge: 1 is rising and 0 is falling. An edge of the other polarity causes no capture.
- R5: A capture copies the counter value as it stands at that clock edge into the capture register, readable at address 2 (high byte) and address 3 (low byte), and sets status bit 0.
- R6: A rising edge on `ramp_mode` sets control bit 0. This takes precedence over a control write in the same cycle.
- R7: A rising edge on `cmp1_flag` or `cmp2_flag` sets status bit 1. `irq_analog` equals status bit 1 AND control bit 1. The flag stays set after the comparator input falls.
- R8: `irq_capture` equals status bit 0 AND control bit 2.
- R9: Writing a 1 to a status bit clears only that bit. A flag event in the same cycle as its clear leaves the flag set.
- R10: `irq_src` is 2'b01 when `irq_capture` is high, 2'b10 when only `irq_analog` is high, and 2'b00 otherwise.
- R11: A read of address 2 holds the capture low byte, so that the next read of address 3 returns the low byte of that same capture even if a newer capture has happened in between.
- R12: `reg_rdata` shows the addressed byte one cycle after a `reg_rd` cycle and holds it until the next read. Addresses 6 and 7 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | Counter advance enable |
| reg_addr | input | 3 | Register address |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |
| cmp1_flag | input | 1 | Comparator 1 output flag |
| cmp2_flag | input | 1 | Comparator 2 output flag |
| cap_pin | input | 1 | External capture input |
| ramp_mode | input | 1 | Ramp-conversion mode select; a rising edge forces the comparator as capture source |
| irq_capture | output | 1 | Capture interrupt request |
| irq_analog | output | 1 | Analog interrupt request |
| irq_src | output | 2 | Highest-priority pending request |

## Verification
One rising edge of `cmp2_flag` can set the capture flag and the analog flag at the same clock edge, so both requests rise together. The bench provokes this with both enables and the comparator source selected. It then checks that `irq_src` names capture first, and that it moves to analog once the capture flag alone is cleared. A flag event can also land in the same cycle as a write-one-to-clear of that flag, and a `ramp_mode` edge can land in the same cycle as a control write. The bench drives each of these pairs on the same clock edge and checks that the flag, or the source select, ends up set.

// File: rtl/ctc_pkg.sv
`timescale 1ns/1ps
package ctc_pkg;
    localparam int unsigned ADDR_W = 3;

    localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
    localparam logic [ADDR_W-1:0] A_STAT = 3'd1;
    localparam logic [ADDR_W-1:0] A_CAPH = 3'd2;
    localparam logic [ADDR_W-1:0] A_CAPL = 3'd3;
    localparam logic [ADDR_W-1:0] A_CNTH = 3'd4;
    localparam logic [ADDR_W-1:0] A_CNTL = 3'd5;

    // control bit positions
    localparam int unsigned B_SRC  = 0;
    localparam int unsigned B_AIE  = 1;
    localparam int unsigned B_CIE  = 2;
    localparam int unsigned B_RISE = 3;
    localparam int unsigned CTRL_BITS = 4;

    // status bit positions
    localparam int unsigned F_CAP = 0;
    localparam int unsigned F_ANA = 1;

    typedef enum logic [1:0] {
        IRQ_NONE = 2'b00,
        IRQ_CAP  = 2'b01,
        IRQ_ANA  = 2'b10
    } irq_src_e;

    typedef struct packed {
        logic pin;
        logic cmp1;
        logic cmp2;
        logic mode;
    } ctc_hist_t;
endpackage

// File: rtl/ctc_counter.sv
`timescale 1ns/1ps
module ctc_counter #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick_en,
    output logic [W-1:0] count
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (tick_en) cnt_d = cnt_q + W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign count = cnt_q;
endmodule

// File: rtl/ctc_edge_sel.sv
`timescale 1ns/1ps
module ctc_edge_sel
    import ctc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic cmp1,
    input  logic cmp2,
    input  logic mode,
    input  logic sel_cmp,
    input  logic rise,
    output logic cap_evt,
    output logic ana_evt,
    output logic mode_evt
);
    ctc_hist_t h_d, h_q;
    logic pin_edge, cmp2_edge;

    always_comb begin
        h_d.pin  = pin;
        h_d.cmp1 = cmp1;
        h_d.cmp2 = cmp2;
        h_d.mode = mode;
        // each source keeps its own history so a source switch makes no edge
        pin_edge  = rise ? (pin  & ~h_q.pin)  : (~pin  & h_q.pin);
        cmp2_edge = rise ? (cmp2 & ~h_q.cmp2) : (~cmp2 & h_q.cmp2);
        cap_evt   = sel_cmp ? cmp2_edge : pin_edge;
        ana_evt   = (cmp1 & ~h_q.cmp1) | (cmp2 & ~h_q.cmp2);
        mode_evt  = mode & ~h_q.mode;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) h_q <= '0;
        else        h_q <= h_d;
    end
endmodule

// File: rtl/ctc_irq_arb.sv
`timescale 1ns/1ps
module ctc_irq_arb
    import ctc_pkg::*;
(
    input  logic       cap_flag,
    input  logic       ana_flag,
    input  logic       cap_ie,
    input  logic       ana_ie,
    output logic       irq_capture,
    output logic       irq_analog,
    output logic [1:0] irq_src
);
    irq_src_e src;

    always_comb begin
        irq_capture = cap_flag & cap_ie;
        irq_analog  = ana_flag & ana_ie;
        if (irq_capture)     src = IRQ_CAP;
        else if (irq_analog) src = IRQ_ANA;
        else                 src = IRQ_NONE;
    end

    assign irq_src = src;
endmodule

// File: rtl/ctc_capture_ctrl.sv
`timescale 1ns/1ps
module ctc_capture_ctrl
    import ctc_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              cmp1_flag,
    input  logic              cmp2_flag,
    input  logic              cap_pin,
    input  logic              ramp_mode,
    output logic              irq_capture,
    output logic              irq_analog,
    output logic [1:0]        irq_src
);
    localparam int unsigned CNT_W = 2 * DATA_W;
    localparam logic [DATA_W-1:0] CTRL_MASK = DATA_W'((1 << CTRL_BITS) - 1);

    typedef struct packed {
        logic [DATA_W-1:0] ctrl;
        logic              cap_flag;
        logic              ana_flag;
        logic [CNT_W-1:0]  cap;
        logic [DATA_W-1:0] lo_hold;
        logic              frozen;
        logic [DATA_W-1:0] rdata;
    } ctc_state_t;

    ctc_state_t s_d, s_q;

    logic [CNT_W-1:0]  cnt_q;
    logic              cap_evt, ana_evt, mode_evt;
    logic [DATA_W-1:0] stat_byte;
    logic              cap_flag_q, ana_flag_q, ctrl_src_q;

    ctc_counter #(.W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_en (tick_en),
        .count   (cnt_q)
    );

    ctc_edge_sel u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin      (cap_pin),
        .cmp1     (cmp1_flag),
        .cmp2     (cmp2_flag),
        .mode     (ramp_mode),
        .sel_cmp  (s_q.ctrl[B_SRC]),
        .rise     (s_q.ctrl[B_RISE]),
        .cap_evt  (cap_evt),
        .ana_evt  (ana_evt),
        .mode_evt (mode_evt)
    );

    assign cap_flag_q = s_q.cap_flag;
    assign ana_flag_q = s_q.ana_flag;
    assign ctrl_src_q = s_q.ctrl[B_SRC];

    always_comb begin
        s_d = s_q;

        stat_byte        = '0;
        stat_byte[F_CAP] = s_q.cap_flag;
        stat_byte[F_ANA] = s_q.ana_flag;

        // control: software write, then mode entry forces comparator source
        if (reg_wr && reg_addr == A_CTRL) s_d.ctrl = reg_wdata & CTRL_MASK;
        if (mode_evt)                     s_d.ctrl[B_SRC] = 1'b1;

        // status: write-one-to-clear, then new events win
        if (reg_wr && reg_addr == A_STAT) begin
            if (reg_wdata[F_CAP]) s_d.cap_flag = 1'b0;
            if (reg_wdata[F_ANA]) s_d.ana_flag = 1'b0;
        end
        if (cap_evt) begin
            s_d.cap_flag = 1'b1;
            s_d.cap      = cnt_q;
        end
        if (ana_evt) s_d.ana_flag = 1'b1;

        // registered read port with low-byte hold on high-byte read
        if (reg_rd) begin
            unique case (reg_addr)
                A_CTRL: s_d.rdata = s_q.ctrl;
                A_STAT: s_d.rdata = stat_byte;
                A_CAPH: begin
                    s_d.rdata   = s_q.cap[CNT_W-1:DATA_W];
                    s_d.lo_hold = s_q.cap[DATA_W-1:0];
                    s_d.frozen  = 1'b1;
                end
                A_CAPL: begin
                    s_d.rdata  = s_q.frozen ? s_q.lo_hold : s_q.cap[DATA_W-1:0];
                    s_d.frozen = 1'b0;
                end
                A_CNTH:  s_d.rdata = cnt_q[CNT_W-1:DATA_W];
                A_CNTL:  s_d.rdata = cnt_q[DATA_W-1:0];
                default: s_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign reg_rdata = s_q.rdata;

    ctc_irq_arb u_arb (
        .cap_flag    (s_q.cap_flag),
        .ana_flag    (s_q.ana_flag),
        .cap_ie      (s_q.ctrl[B_CIE]),
        .ana_ie      (s_q.ctrl[B_AIE]),
        .irq_capture (irq_capture),
        .irq_analog  (irq_analog),
        .irq_src     (irq_src)
    );
endmodule

// File: rtl/ctc_capture_ctrl_chk.sv
`timescale 1ns/1ps
module ctc_capture_ctrl_chk
    import ctc_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick_en,
    input logic [CNT_W-1:0]  cnt,
    input logic              cap_flag,
    input logic              ana_flag,
    input logic              ctrl_src,
    input logic              ramp_mode,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [1:0]        clr_bits,
    input logic              cap_evt,
    input logic              ana_evt,
    input logic              irq_capture,
    input logic              irq_analog,
    input logic [1:0]        irq_src
);
    // R1
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_en |=> cnt == CNT_W'($past(cnt) + 1'b1));

    // R1
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_en |=> $stable(cnt));

    // R5
    cap_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cap_evt |=> cap_flag);

    // R7
    ana_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ana_evt |=> ana_flag);

    // R9
    cap_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_flag && !(reg_wr && reg_addr == A_STAT && clr_bits[F_CAP])) |=> cap_flag);

    // R9
    ana_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ana_flag && !(reg_wr && reg_addr == A_STAT && clr_bits[F_ANA])) |=> ana_flag);

    // R6
    mode_sets_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ramp_mode) |=> ctrl_src);

    // R10
    irq_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(irq_src));

    // R10
    irq_any_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_capture || irq_analog) |-> irq_src != 2'b00);
endmodule

bind ctc_capture_ctrl ctc_capture_ctrl_chk #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_en     (tick_en),
    .cnt         (cnt_q),
    .cap_flag    (cap_flag_q),
    .ana_flag    (ana_flag_q),
    .ctrl_src    (ctrl_src_q),
    .ramp_mode   (ramp_mode),
    .reg_wr      (reg_wr),
    .reg_addr    (reg_addr),
    .clr_bits    (reg_wdata[1:0]),
    .cap_evt     (cap_evt),
    .ana_evt     (ana_evt),
    .irq_capture (irq_capture),
    .irq_analog  (irq_analog),
    .irq_src     (irq_src)
);

// File: tb/ctc_capture_ctrl_tb.sv
`timescale 1ns/1ps
module ctc_capture_ctrl_tb;
    localparam int CW = 16;

    logic clk = 1'b0, rst_n = 1'b0, tick_en = 1'b0;
    logic reg_wr = 1'b0, reg_rd = 1'b0;
    logic cmp1 = 1'b0, cmp2 = 1'b0, cap_pin = 1'b0, ramp_mode = 1'b0;
    logic [2:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic irq_capture, irq_analog;
    logic [1:0] irq_src;

    always #2 clk = ~clk; // 4 ns period

    ctc_capture_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .cmp1_flag(cmp1), .cmp2_flag(cmp2), .cap_pin(cap_pin),
        .ramp_mode(ramp_mode), .irq_capture(irq_capture),
        .irq_analog(irq_analog), .irq_src(irq_src)
    );

    int checks = 0, errors = 0;

    // reference model state
    logic [CW-1:0] m_cnt = '0, pre_cnt = '0, m_cap = '0, m_cap_old = '0;
    logic [7:0] m_hold = '0, exp_rd = '0;
    logic m_frz = 0, m_capf = 0, m_anaf = 0, m_src = 0, m_aie = 0, m_cie = 0, m_rise = 0;
    logic p_pin = 0, p_c1 = 0, p_c2 = 0, p_mode = 0;

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // one clock with the reference model advanced at the edge
    task automatic step();
        logic ev_cap, ev_ana, ev_mode;
        @(posedge clk);
        pre_cnt   = m_cnt;
        m_cap_old = m_cap;
        if (m_src) ev_cap = m_rise ? (cmp2 & ~p_c2) : (~cmp2 & p_c2);
        else       ev_cap = m_rise ? (cap_pin & ~p_pin) : (~cap_pin & p_pin);
        ev_ana  = (cmp1 & ~p_c1) | (cmp2 & ~p_c2);
        ev_mode = ramp_mode & ~p_mode;
        if (reg_rd) begin
            case (reg_addr)
                3'd0: exp_rd = {4'b0, m_rise, m_cie, m_aie, m_src};
                3'd1: exp_rd = {6'b0, m_anaf, m_capf};
                3'd2: begin exp_rd = m_cap_old[15:8]; m_hold = m_cap_old[7:0]; m_frz = 1; end
                3'd3: begin exp_rd = m_frz ? m_hold : m_cap_old[7:0]; m_frz = 0; end
                3'd4: exp_rd = pre_cnt[15:8];
                3'd5: exp_rd = pre_cnt[7:0];
                default: exp_rd = 8'h00;
            endcase
        end
        if (tick_en) m_cnt = m_cnt + 1'b1;
        if (reg_wr && reg_addr == 3'd0) begin
            m_src = reg_wdata[0]; m_aie = reg_wdata[1];
            m_cie = reg_wdata[2]; m_rise = reg_wdata[3];
        end
        if (reg_wr && reg_addr == 3'd1) begin
            if (reg_wdata[0]) m_capf = 0;
            if (reg_wdata[1]) m_anaf = 0;
        end
        if (ev_mode) m_src = 1;
        if (ev_cap) begin m_capf = 1; m_cap = pre_cnt; end
        if (ev_ana) m_anaf = 1;
        p_pin = cap_pin; p_c1 = cmp1; p_c2 = cmp2; p_mode = ramp_mode;
        @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1; step(); reg_wr = 0;
    endtask

    task automatic rd(input logic [2:0] a, input string req, output logic [7:0] v);
        reg_addr = a; reg_rd = 1; step(); reg_rd = 0;
        v = reg_rdata;
        check(req, {8'h00, v}, {8'h00, exp_rd});
    endtask

    task automatic check_irq(input string req);
        logic ec, ea;
        logic [1:0] es;
        ec = m_capf & m_cie;
        ea = m_anaf & m_aie;
        es = ec ? 2'b01 : (ea ? 2'b10 : 2'b00);
        check({req, " irq_capture"}, {15'b0, irq_capture}, {15'b0, ec});
        check({req, " irq_analog"}, {15'b0, irq_analog}, {15'b0, ea});
        check({req, " irq_src"}, {14'b0, irq_src}, {14'b0, es});
    endtask

    initial begin : watchdog
        #(200000 * 4);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        logic [7:0] v, hi_a;
        logic [15:0] cap_a;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R2 reset state
        rd(3'd0, "R2 ctrl", v); check("R2 ctrl zero", {8'h0, v}, 16'h0);
        rd(3'd1, "R2 stat", v); check("R2 stat zero", {8'h0, v}, 16'h0);
        rd(3'd5, "R2 cnt", v);  check("R2 cnt zero", {8'h0, v}, 16'h0);
        check_irq("R2");

        // R1 counter gating
        tick_en = 1; repeat (10) step();
        tick_en = 0; repeat (3) step();
        rd(3'd5, "R1 cnt lo", v); check("R1 cnt lo is 10", {8'h0, v}, 16'd10);
        rd(3'd4, "R1 cnt hi", v); check("R1 cnt hi is 0", {8'h0, v}, 16'd0);
        tick_en = 1;

        // R3/R4/R5/R8 pin source, rising edge
        wr(3'd0, 8'h0C);
        cap_pin = 1; step();
        check_irq("R8 pin capture");
        check("R5 capture value", m_cap, pre_cnt);
        rd(3'd2, "R5 cap hi", v);
        rd(3'd3, "R5 cap lo", v);
        rd(3'd1, "R5 stat", v); check("R5 stat bit0", {8'h0, v}, 16'h01);

        // R9 clear, R4 wrong polarity ignored
        wr(3'd1, 8'h01); check_irq("R9 cleared");
        cap_pin = 0; step();
        rd(3'd1, "R4 falling ignored", v); check("R4 no capture", {8'h0, v}, 16'h00);

        // R4 falling edge mode
        wr(3'd0, 8'h04);
        cap_pin = 1; step();
        rd(3'd1, "R4 rising ignored", v); check("R4 no capture on rise", {8'h0, v}, 16'h00);
        cap_pin = 0; step();
        rd(3'd1, "R4 falling capture", v); check("R4 capture on fall", {8'h0, v}, 16'h01);

        // R3 comparator source; pin ignored; R7 gating by enable
        wr(3'd0, 8'h0D); wr(3'd1, 8'h03);
        cap_pin = 1; step(); cap_pin = 0; step();
        rd(3'd1, "R3 pin ignored", v); check("R3 no pin capture", {8'h0, v}, 16'h00);
        cmp2 = 1; step();
        check_irq("R7 analog masked");
        check("R7 masked analog low", {15'b0, irq_analog}, 16'h0);
        rd(3'd1, "R3 cmp2 capture", v); check("R3 both flags", {8'h0, v}, 16'h03);
        rd(3'd2, "R3 cap hi", v); rd(3'd3, "R3 cap lo", v);

        // R7 analog pending after comparator returns low
        cmp2 = 0; wr(3'd1, 8'h03); wr(3'd0, 8'h02);
        cmp1 = 1; step(); cmp1 = 0; step(); step();
        check_irq("R7 pending");
        check("R7 analog held", {15'b0, irq_analog}, 16'h1);

        // R10 both paths from one comparator-2 edge
        wr(3'd1, 8'h03); wr(3'd0, 8'h0F);
        cmp2 = 1; step();
        check("R10 capture first", {14'b0, irq_src}, 16'h1);
        check_irq("R10 both");
        cmp2 = 0;
        wr(3'd1, 8'h01);
        check("R10 analog next", {14'b0, irq_src}, 16'h2);
        check("R9 analog kept", {15'b0, irq_analog}, 16'h1);
        wr(3'd1, 8'h02);
        check("R10 none", {14'b0, irq_src}, 16'h0);
        // R9 clearing analog leaves capture
        cmp2 = 1; step(); cmp2 = 0; step();
        wr(3'd1, 8'h02);
        rd(3'd1, "R9 cap kept", v); check("R9 cap kept value", {8'h0, v}, 16'h01);
        wr(3'd1, 8'h01);

        // R6 mode entry sets source, beats a same-cycle write
        wr(3'd0, 8'h00);
        ramp_mode = 1; step();
        rd(3'd0, "R6 src set", v); check("R6 src bit", {8'h0, v}, 16'h01);
        ramp_mode = 0; step();
        ramp_mode = 1; wr(3'd0, 8'h00);
        rd(3'd0, "R6 src beats write", v); check("R6 src wins", {8'h0, v}, 16'h01);
        ramp_mode = 0;

        // R11 low-byte hold across a newer capture
        wr(3'd0, 8'h08); cap_pin = 0; step();
        cap_pin = 1; step(); cap_a = m_cap;
        repeat (5) step();
        rd(3'd2, "R11 hi", hi_a);
        cap_pin = 0; step(); cap_pin = 1; step();
        rd(3'd3, "R11 lo held", v);
        check("R11 pair", {hi_a, v}, cap_a);
        rd(3'd2, "R11 new hi", v); rd(3'd3, "R11 new lo", v);

        // R9 set wins over same-cycle clear
        wr(3'd1, 8'h03); cap_pin = 0; step();
        cap_pin = 1; wr(3'd1, 8'h01);
        rd(3'd1, "R9 set wins", v); check("R9 set wins value", {8'h0, v}, 16'h01);

        // R12 unused address and hold
        rd(3'd7, "R12 unused", v); check("R12 zero", {8'h0, v}, 16'h0);
        step(); check("R12 hold", {8'h0, reg_rdata}, 16'h0);

        // constrained random phase
        for (int i = 0; i < 600; i++) begin
            int unsigned op;
            op = $urandom_range(0, 9);
            cmp1      = ($urandom_range(0, 3) == 0);
            cmp2      = ($urandom_range(0, 2) == 0);
            cap_pin   = $urandom_range(0, 1);
            tick_en   = ($urandom_range(0, 3) != 0);
            ramp_mode = ($urandom_range(0, 15) == 0);
            if (op == 0)      wr(3'd0, 8'($urandom_range(0, 15)));
            else if (op == 1) wr(3'd1, 8'($urandom_range(0, 3)));
            else if (op < 5)  rd(3'($urandom_range(0, 7)), "R5 R11 R12 random read", v);
            else              step();
            check_irq("R7 R8 R10 random");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule